// File: doc/BRIEF.md
# Receive Buffer Block Allocator

The allocator tracks which fixed-size packet buffer blocks are free and which hold a packet, using one occupancy bit per block. When the receive side starts taking in a frame, it raises a request. In the next cycle the allocator returns the lowest-numbered free block, its byte address in buffer memory, and marks the block as in use.

A block goes back to the pool by one of two routes. The receive side hands it back when the frame is aborted, for example by a collision, a FIFO overflow or a transfer fault. The transmit side hands it back when the last transmission out of that block has completed. Both routes can act in the same cycle as an allocation.

The block also reports how many blocks are free and raises an out-of-buffers flag while none are left. A sticky error flag records any release that names a block which is not in use. The pool size is a parameter. The two memory configurations use 576 and 1248 blocks of 1536 bytes each.

Top module: `rxbuf_alloc`

## Requirements
- R1: After reset every block is free: the free count equals NUM_BLOCKS, and the grant, out-of-buffers and release-error outputs are low.
- R2: A request sampled at a clock edge while a block is free makes the grant high for the following cycle. The granted number is the lowest-numbered free block, and that block counts as in use from then on.
- R3: With each grant, the address output equals BASE_ADDR + block × BLOCK_BYTES.
- R4: A receive-abort release of an in-use block returns it to the pool, and it can be granted again.
- R5: A transmit-done release of an in-use block returns it to the pool, and it can be granted again.
- R6: While no block is free, a request produces no grant, and the out-of-buffers output is high exactly when the free count is zero.
- R7: After each edge the free count equals its previous value, minus one for a grant, plus one for each accepted release. This holds when these events fall in the same cycle.
- R8: A release that names a free block, or one past the pool, leaves the occupancy unchanged and sets the release-error output. That output stays high until reset. When both release routes name the same in-use block in one cycle, the block is freed once and the error is set.
- R9: The search for a grant uses the occupancy as it was before the releases of the same cycle. A block freed in a cycle is not the one granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Receive side asks for a free block |
| rx_rel_vld | input | 1 | Receive abort: release the block on rx_rel_blk |
| rx_rel_blk | input | BLK_W | Block number released by the receive side |
| tx_rel_vld | input | 1 | Transmit done: release the block on tx_rel_blk |
| tx_rel_blk | input | BLK_W | Block number released by the transmit side |
| alloc_gnt | output | 1 | Registered grant, one cycle after a served request |
| alloc_blk | output | BLK_W | Granted block number |
| alloc_addr | output | ADDR_W | Base byte address of the granted block |
| free_cnt | output | CNT_W | Number of free blocks |
| no_buf | output | 1 | High while no block is free |
| rel_err | output | 1 | Sticky flag for a bad release |

## Verification
The bench builds the allocator with NUM_BLOCKS = 8 and GROUP_W = 4. This gives two search groups, so the bench can fill the pool completely in a few cycles. It also lets the bench observe a grant that moves from the first group to the second. With these values, exhaustion, refill after a release, and the lowest-free ordering across a group boundary are all in reach. The bench also places an allocation in the same cycle as a release, and sends the same block down both release routes at once. The address check uses the default 1536-byte block size and the default buffer base.

// File: rtl/rxbuf_alloc_pkg.sv
package rxbuf_alloc_pkg;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rxbuf_group_scan.sv
module rxbuf_group_scan #(
  parameter int unsigned GW   = 32,
  parameter int unsigned GW_W = 5
) (
  input  logic [GW-1:0]   used,
  output logic            any_free,
  output logic [GW_W-1:0] low_idx
);

  always_comb begin
    any_free = 1'b0;
    low_idx  = '0;
    for (int i = int'(GW) - 1; i >= 0; i--) begin
      if (!used[i]) begin
        any_free = 1'b1;
        low_idx  = GW_W'(i);
      end
    end
  end

endmodule

// File: rtl/rxbuf_free_find.sv
module rxbuf_free_find
  import rxbuf_alloc_pkg::*;
#(
  parameter int unsigned N     = 576,
  parameter int unsigned GW    = 32,
  parameter int unsigned BLK_W = 10
) (
  input  logic [N-1:0]     used,
  output logic             found,
  output logic [BLK_W-1:0] idx
);

  localparam int unsigned NG   = ceil_div(N, GW);
  localparam int unsigned GW_W = idx_w(GW);
  localparam int unsigned PADN = NG * GW;

  logic [PADN-1:0]           used_pad;
  logic [NG-1:0]             g_any;
  logic [NG-1:0][GW_W-1:0]   g_idx;

  generate
    if (PADN > N) begin : g_pad
      assign used_pad = {{(PADN - N){1'b1}}, used};
    end else begin : g_nopad
      assign used_pad = used;
    end
    for (genvar g = 0; g < int'(NG); g++) begin : g_grp
      rxbuf_group_scan #(.GW(GW), .GW_W(GW_W)) u_scan (
        .used     (used_pad[g*GW +: GW]),
        .any_free (g_any[g]),
        .low_idx  (g_idx[g])
      );
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int g = int'(NG) - 1; g >= 0; g--) begin
      if (g_any[g]) begin
        found = 1'b1;
        idx   = BLK_W'(g * int'(GW)) + BLK_W'(g_idx[g]);
      end
    end
  end

endmodule

// File: rtl/rxbuf_alloc.sv
module rxbuf_alloc
  import rxbuf_alloc_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS  = 576,
  parameter int unsigned GROUP_W     = 32,
  parameter int unsigned BLOCK_BYTES = 1536,
  parameter int unsigned BASE_ADDR   = 32'h0002_8000,
  parameter int unsigned ADDR_W      = 24,
  localparam int unsigned BLK_W      = idx_w(NUM_BLOCKS),
  localparam int unsigned CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic              rx_rel_vld,
  input  logic [BLK_W-1:0]  rx_rel_blk,
  input  logic              tx_rel_vld,
  input  logic [BLK_W-1:0]  tx_rel_blk,
  output logic              alloc_gnt,
  output logic [BLK_W-1:0]  alloc_blk,
  output logic [ADDR_W-1:0] alloc_addr,
  output logic [CNT_W-1:0]  free_cnt,
  output logic              no_buf,
  output logic              rel_err
);

  logic [NUM_BLOCKS-1:0] used_q, used_d;
  logic                  fnd_any;
  logic [BLK_W-1:0]      fnd_idx;
  logic                  gnt_now, rx_ok, tx_ok, err_now, rx_in, tx_in;
  logic [CNT_W-1:0]      cnt_d;

  rxbuf_free_find #(.N(NUM_BLOCKS), .GW(GROUP_W), .BLK_W(BLK_W)) u_find (
    .used  (used_q),
    .found (fnd_any),
    .idx   (fnd_idx)
  );

  // Release vetting and next occupancy; the search sees used_q (pre-release).
  always_comb begin
    rx_in   = int'(rx_rel_blk) < int'(NUM_BLOCKS);
    tx_in   = int'(tx_rel_blk) < int'(NUM_BLOCKS);
    rx_ok   = rx_rel_vld && rx_in && used_q[rx_rel_blk];
    tx_ok   = tx_rel_vld && tx_in && used_q[tx_rel_blk]
              && !(rx_rel_vld && rx_rel_blk == tx_rel_blk);
    err_now = (rx_rel_vld && !rx_ok) || (tx_rel_vld && !tx_ok);
    gnt_now = alloc_req && fnd_any;
    used_d  = used_q;
    if (rx_ok)   used_d[rx_rel_blk] = 1'b0;
    if (tx_ok)   used_d[tx_rel_blk] = 1'b0;
    if (gnt_now) used_d[fnd_idx]    = 1'b1;
    cnt_d   = free_cnt - CNT_W'(gnt_now) + CNT_W'(rx_ok) + CNT_W'(tx_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q     <= '0;
      alloc_gnt  <= 1'b0;
      alloc_blk  <= '0;
      alloc_addr <= '0;
      free_cnt   <= CNT_W'(NUM_BLOCKS);
      no_buf     <= 1'b0;
      rel_err    <= 1'b0;
    end else begin
      used_q    <= used_d;
      alloc_gnt <= gnt_now;
      if (gnt_now) begin
        alloc_blk  <= fnd_idx;
        alloc_addr <= ADDR_W'(BASE_ADDR) + ADDR_W'(fnd_idx) * ADDR_W'(BLOCK_BYTES);
      end
      free_cnt  <= cnt_d;
      no_buf    <= (cnt_d == '0);
      rel_err   <= rel_err | err_now;
    end
  end

  // ---------------- assertions ----------------
  p_pick_is_free_r2: assert property (@(posedge clk) disable iff (rst)
    fnd_any |-> !used_q[fnd_idx]);

  p_gnt_marks_used_r2: assert property (@(posedge clk) disable iff (rst)
    gnt_now |=> used_q[$past(fnd_idx)]);

  p_empty_no_gnt_r6: assert property (@(posedge clk) disable iff (rst)
    (free_cnt == '0) |-> !fnd_any);

  p_nobuf_match_r6: assert property (@(posedge clk) disable iff (rst)
    no_buf == (free_cnt == '0));

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CNT_W'(NUM_BLOCKS));

  p_cnt_popcount_r7: assert property (@(posedge clk) disable iff (rst)
    int'(free_cnt) == int'(NUM_BLOCKS) - $countones(used_q));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    rel_err |=> rel_err);

  p_bad_rel_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_rel_vld && rx_in && !used_q[rx_rel_blk] && !gnt_now) |=>
      !used_q[$past(rx_rel_blk)]);

endmodule

// File: tb/rxbuf_alloc_tb.sv
module rxbuf_alloc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 8;
  localparam int GW    = 4;
  localparam int BYTES = 1536;
  localparam int BASE  = 'h28000;
  localparam int AW    = 24;
  localparam int BW    = 3;
  localparam int CW    = 4;

  typedef struct packed {
    logic          req;
    logic          rxv;
    logic [BW-1:0] rxb;
    logic          txv;
    logic [BW-1:0] txb;
    logic          egnt;
    logic [BW-1:0] eblk;
    logic [CW-1:0] ecnt;
    logic          enob;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0, 4'd7, 1'b0},  // R2 lowest
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd1, 4'd6, 1'b0},
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd2, 4'd5, 1'b0},
    '{1'b0, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 3'd0, 4'd6, 1'b0},  // R4 abort 1
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd1, 4'd5, 1'b0},  // R4 reuse 1
    '{1'b1, 1'b0, 3'd0, 1'b1, 3'd0, 1'b1, 3'd3, 4'd5, 1'b0},  // R9/R5/R7
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0, 4'd4, 1'b0},  // R5 reuse 0
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd4, 4'd3, 1'b0},  // group 2
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5, 4'd2, 1'b0},
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd6, 4'd1, 1'b0},
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd7, 4'd0, 1'b1},  // R6 empty
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd0, 1'b1},  // R6 no gnt
    '{1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 3'd0, 4'd1, 1'b0},  // R5 free 3
    '{1'b1, 1'b1, 3'd5, 1'b0, 3'd0, 1'b1, 3'd3, 4'd1, 1'b0},  // R9 not 5
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5, 4'd0, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_req = 1'b0, rx_rel_vld = 1'b0, tx_rel_vld = 1'b0;
  logic [BW-1:0] rx_rel_blk = '0, tx_rel_blk = '0;
  logic alloc_gnt, no_buf, rel_err;
  logic [BW-1:0] alloc_blk;
  logic [AW-1:0] alloc_addr;
  logic [CW-1:0] free_cnt;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_alloc #(.NUM_BLOCKS(NB), .GROUP_W(GW), .BLOCK_BYTES(BYTES),
                .BASE_ADDR(BASE), .ADDR_W(AW)) u_dut (
    .clk, .rst, .alloc_req, .rx_rel_vld, .rx_rel_blk, .tx_rel_vld, .tx_rel_blk,
    .alloc_gnt, .alloc_blk, .alloc_addr, .free_cnt, .no_buf, .rel_err);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic rv, input int rb,
                      input logic tv, input int tb);
    @(negedge clk);
    alloc_req = rq; rx_rel_vld = rv; rx_rel_blk = BW'(rb);
    tx_rel_vld = tv; tx_rel_blk = BW'(tb);
    @(posedge clk); #1;
    @(negedge clk);
    alloc_req = 1'b0; rx_rel_vld = 1'b0; tx_rel_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 count", int'(free_cnt), NB);
    chk("R1 gnt", int'(alloc_gnt), 0);
    chk("R1 nobuf", int'(no_buf), 0);
    chk("R1 err", int'(rel_err), 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      alloc_req = VEC[v].req; rx_rel_vld = VEC[v].rxv; rx_rel_blk = VEC[v].rxb;
      tx_rel_vld = VEC[v].txv; tx_rel_blk = VEC[v].txb;
      @(posedge clk); #1;
      chk($sformatf("R2 gnt v%0d", v), int'(alloc_gnt), int'(VEC[v].egnt));
      if (VEC[v].egnt) begin
        chk($sformatf("R2 blk v%0d", v), int'(alloc_blk), int'(VEC[v].eblk));
        chk($sformatf("R3 addr v%0d", v), int'(alloc_addr),
            BASE + int'(VEC[v].eblk) * BYTES);
      end
      chk($sformatf("R7 cnt v%0d", v), int'(free_cnt), int'(VEC[v].ecnt));
      chk($sformatf("R6 nobuf v%0d", v), int'(no_buf), int'(VEC[v].enob));
      chk($sformatf("R8 err v%0d", v), int'(rel_err), 0);
    end
    @(negedge clk); alloc_req = 1'b0; rx_rel_vld = 1'b0; tx_rel_vld = 1'b0;

    // all 8 used now; free 2, then release 2 again
    step(1'b0, 1'b1, 2, 1'b0, 0);
    chk("R4 cnt", int'(free_cnt), 1);
    chk("R8 clean", int'(rel_err), 0);
    step(1'b0, 1'b1, 2, 1'b0, 0);
    chk("R8 err set", int'(rel_err), 1);
    chk("R8 cnt kept", int'(free_cnt), 1);
    step(1'b1, 1'b0, 0, 1'b0, 0);
    chk("R8 gnt", int'(alloc_gnt), 1);
    chk("R8 blk", int'(alloc_blk), 2);
    chk("R8 sticky", int'(rel_err), 1);
    // both routes name block 4 in one cycle
    step(1'b0, 1'b1, 4, 1'b1, 4);
    chk("R8 dual cnt", int'(free_cnt), 1);
    step(1'b1, 1'b0, 0, 1'b0, 0);
    chk("R8 dual blk", int'(alloc_blk), 4);
    chk("R8 dual empty", int'(no_buf), 1);

    // reset clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 re cnt", int'(free_cnt), NB);
    chk("R1 re err", int'(rel_err), 0);
    step(1'b1, 1'b0, 0, 1'b0, 0);
    chk("R1 re blk", int'(alloc_blk), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule